// File: doc/BRIEF.md
# Disciplined Sample-Clock Timebase

This block is the time base of a sampling device. A 64-bit tick count advances by one on every clock edge, and a small command port lets a controller change the count in three ways. It can overwrite the count at once. It can stage a value that takes over at the next pulse-per-second (PPS) event. It can also add a signed correction to the running count inside the block, with a fixed latency, so that software never has to read the count, add to it and write it back across a link whose delay cannot be predicted.

The PPS event comes from one of two sources. The first is an external pulse, which passes through a synchroniser and a rising-edge detector. The second is an internal generator that fires once every programmable number of ticks. Each event copies the count into a capture register, and a staged value, if one is waiting, is loaded at that event. The command port is a valid/ready channel. It stalls only while one command is still waiting to be applied, so a controller must hold `cmd_valid`, `cmd_op` and `cmd_data` steady until it sees `cmd_ready` high at a clock edge. One command is taken per handshake.

Top module: `tick_timebase`

## Requirements
- R1: A set-now command (`cmd_op` = 0) accepted at a clock edge makes `time_now` equal to `cmd_data` right after that edge, unless a staged load happens at the same edge (see R7).
- R2: A set-on-PPS command (`cmd_op` = 1) only stores `cmd_data` and raises `pps_armed`. The count loads that value at the first PPS event after the accepting edge, and `pps_armed` goes low at that same edge. An event at the accepting edge itself does not consume the new value.
- R3: An adjust command (`cmd_op` = 2) carries a two's-complement delta. Two edges after the command is accepted, `time_now` equals the value it would have had without the command plus the delta, taken modulo 2^64. A negative delta steps the count backward.
- R4: At every PPS event, `time_at_pps` takes the value `time_now` had during the event cycle. `pps_tick` is high during that cycle.
- R5: With `pps_int_sel` = 1, events come from the internal generator, one every `pps_period` cycles. A period below 2 is treated as 2.
- R6: With `pps_int_sel` = 0, a rising edge on `pps_ext` is seen two clock edges later, when `pps_tick` goes high for one cycle. A pulse held high for many cycles counts as one event.
- R7: If a set-now arrives, or an adjust falls due, at the same edge as a staged load, the staged load wins. The other command is applied at the following edge on top of the newly loaded count.
- R8: Without commands or loads, `time_now` grows by one per cycle, starting from 0 after reset. `cmd_ready` is low for exactly the cycles in which an accepted adjust or a deferred set-now is still waiting to be applied.
- R9: `cmd_op` = 3 is accepted and has no effect on the count or on the staged state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 set-now, 1 set-on-PPS, 2 adjust, 3 no operation |
| cmd_data | input | 64 | Load value or signed delta |
| pps_ext | input | 1 | Asynchronous external pulse |
| pps_int_sel | input | 1 | 1 selects the internal generator |
| pps_period | input | 32 | Internal generator period in ticks |
| time_now | output | 64 | Running tick count |
| time_at_pps | output | 64 | Count captured at the last PPS event |
| pps_armed | output | 1 | A staged value is waiting for an event |
| pps_tick | output | 1 | PPS event in this cycle |

## Verification
A set-now shows on `time_now` one edge after acceptance. An adjust shows two edges after acceptance, and a command that collides with a staged load shows one edge later than that. A staged load and the matching `time_at_pps` capture appear one edge after the cycle in which `pps_tick` is high, and an external edge reaches `pps_tick` two edges after it is driven. The bench drives its inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output with the model at each falling edge, and its directed checks sample exactly at the falling edge that follows the edge count above.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    OP_SET_NOW = 2'd0,
    OP_SET_PPS = 2'd1,
    OP_ADJUST  = 2'd2,
    OP_NOP     = 2'd3
  } tt_op_e;
endpackage

// File: rtl/tt_pps_source.sv
module tt_pps_source #(
  parameter int PER_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_ext,
  input  logic             int_sel,
  input  logic [PER_W-1:0] period,
  output logic             pps_evt
);
  localparam logic [PER_W-1:0] MIN_PER = PER_W'(2);

  // synchroniser chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sh;
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[g] <= 1'b0;
        else if (g == 0) sh[g] <= pps_ext;
        else sh[g] <= sh[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  logic ext_evt;
  assign ext_evt = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  // internal pulse generator
  logic [PER_W-1:0] per_eff, pcnt;
  logic             gen_evt;
  assign per_eff = (period < MIN_PER) ? MIN_PER : period;
  assign gen_evt = (pcnt >= per_eff - PER_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (gen_evt) pcnt <= '0;
    else              pcnt <= pcnt + PER_W'(1);
  end

  assign pps_evt = int_sel ? gen_evt : ext_evt;
endmodule

// File: rtl/tt_cmd_stage.sv
module tt_cmd_stage
  import tt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_data,
  input  logic             load_now,
  output logic             imm_set,
  output logic             app_set,
  output logic             app_adj,
  output logic [CNT_W-1:0] app_val,
  output logic             arm_wr
);
  logic             pend_q;
  tt_op_e           pend_op_q;
  logic [CNT_W-1:0] pend_val_q;
  logic             acc, is_set, is_adj, apply;

  assign cmd_ready = ~pend_q;
  assign acc       = cmd_valid & ~pend_q;
  assign is_set    = acc & (tt_op_e'(cmd_op) == OP_SET_NOW);
  assign is_adj    = acc & (tt_op_e'(cmd_op) == OP_ADJUST);
  assign arm_wr    = acc & (tt_op_e'(cmd_op) == OP_SET_PPS);
  assign imm_set   = is_set & ~load_now;

  assign apply   = pend_q & ~load_now;
  assign app_set = apply & (pend_op_q == OP_SET_NOW);
  assign app_adj = apply & (pend_op_q == OP_ADJUST);
  assign app_val = pend_val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_op_q  <= OP_NOP;
      pend_val_q <= '0;
    end else if (is_adj || (is_set && load_now)) begin
      pend_q     <= 1'b1;
      pend_op_q  <= tt_op_e'(cmd_op);
      pend_val_q <= cmd_data;
    end else if (apply) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tt_clock_core.sv
module tt_clock_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_evt,
  input  logic             imm_set,
  input  logic [CNT_W-1:0] imm_val,
  input  logic             app_set,
  input  logic             app_adj,
  input  logic [CNT_W-1:0] app_val,
  input  logic             arm_wr,
  input  logic [CNT_W-1:0] arm_val,
  output logic             load_now,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] captured,
  output logic             armed
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] hold_q;

  assign load_now = pps_evt & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (load_now) count <= hold_q;
    else if (app_set)  count <= app_val;
    else if (app_adj)  count <= count + ONE + app_val;
    else if (imm_set)  count <= imm_val;
    else               count <= count + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      armed  <= 1'b0;
    end else if (arm_wr) begin
      hold_q <= arm_val;
      armed  <= 1'b1;
    end else if (load_now) begin
      armed  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       captured <= '0;
    else if (pps_evt) captured <= count;
  end
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int CNT_W       = 64,
  parameter int PER_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_data,
  input  logic             pps_ext,
  input  logic             pps_int_sel,
  input  logic [PER_W-1:0] pps_period,
  output logic [CNT_W-1:0] time_now,
  output logic [CNT_W-1:0] time_at_pps,
  output logic             pps_armed,
  output logic             pps_tick
);
  logic             load_now, imm_set, app_set, app_adj, arm_wr;
  logic [CNT_W-1:0] app_val;

  tt_pps_source #(.PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .pps_ext(pps_ext), .int_sel(pps_int_sel),
    .period(pps_period), .pps_evt(pps_tick)
  );

  tt_cmd_stage #(.CNT_W(CNT_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .load_now(load_now),
    .imm_set(imm_set), .app_set(app_set), .app_adj(app_adj),
    .app_val(app_val), .arm_wr(arm_wr)
  );

  tt_clock_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .pps_evt(pps_tick),
    .imm_set(imm_set), .imm_val(cmd_data),
    .app_set(app_set), .app_adj(app_adj), .app_val(app_val),
    .arm_wr(arm_wr), .arm_val(cmd_data), .load_now(load_now),
    .count(time_now), .captured(time_at_pps), .armed(pps_armed)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic [CNT_W-1:0] cmd_data,
  input logic [CNT_W-1:0] time_now,
  input logic [CNT_W-1:0] time_at_pps,
  input logic             pps_armed,
  input logic             pps_tick
);
  AST_SETNOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd0 && !(pps_tick && pps_armed))
      |=> (time_now == $past(cmd_data))); // R1
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_tick && pps_armed && !(cmd_valid && cmd_ready && cmd_op == 2'd1))
      |=> !pps_armed); // R2
  AST_PPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pps_tick |=> (time_at_pps == $past(time_now))); // R4
  AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    pps_tick |=> !pps_tick); // R6
  AST_COLLIDE_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd0 && pps_tick && pps_armed)
      |=> !cmd_ready); // R7
  AST_ADJ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> !cmd_ready); // R8
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid && !pps_tick)
      |=> (time_now == $past(time_now) + CNT_W'(1))); // R8
endmodule

bind tick_timebase tt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .time_now(time_now),
  .time_at_pps(time_at_pps), .pps_armed(pps_armed), .pps_tick(pps_tick)
);

// File: tb/sim_tick_timebase.sv
`timescale 1ns/1ps
module sim_tick_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd3;
  logic [63:0] cmd_data = '0;
  logic        pps_ext = 1'b0;
  logic        pps_int_sel = 1'b0;
  logic [31:0] pps_period = 32'd0;
  logic [63:0] time_now, time_at_pps;
  logic        pps_armed, pps_tick;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_timebase u0 (.*);

  // behavioural reference model
  logic [63:0] m_cnt, m_hold, m_last, m_pval;
  logic        m_armed, m_pend, m_s1, m_s2, m_s3;
  logic [1:0]  m_pop;
  longint unsigned m_pc;
  logic        m_evt;

  function automatic logic model_evt();
    longint unsigned per;
    per = (pps_period < 2) ? 2 : longint'(pps_period);
    if (pps_int_sel) return (m_pc >= per - 1);
    return m_s2 && !m_s3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_last = 0; m_pval = 0; m_armed = 0;
      m_pend = 0; m_pop = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pc = 0;
    end else begin
      logic ev, ld, acc;
      logic [63:0] c;
      longint unsigned per;
      ev  = model_evt();
      ld  = ev && m_armed;
      acc = cmd_valid && !m_pend;
      c   = m_cnt;
      if (ev) m_last = c;
      if (ld) m_cnt = m_hold;
      else if (m_pend) m_cnt = (m_pop == 2'd0) ? m_pval : c + 64'd1 + m_pval;
      else if (acc && cmd_op == 2'd0) m_cnt = cmd_data;
      else m_cnt = c + 64'd1;
      if (acc && (cmd_op == 2'd2 || (cmd_op == 2'd0 && ld))) begin
        m_pend = 1; m_pop = cmd_op; m_pval = cmd_data;
      end else if (m_pend && !ld) m_pend = 0;
      if (acc && cmd_op == 2'd1) begin m_hold = cmd_data; m_armed = 1; end
      else if (ld) m_armed = 0;
      per = (pps_period < 2) ? 2 : longint'(pps_period);
      if (m_pc >= per - 1) m_pc = 0; else m_pc = m_pc + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pps_ext;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      m_evt = model_evt();
      n_run++;
      if (time_now !== m_cnt || time_at_pps !== m_last || pps_armed !== m_armed ||
          cmd_ready !== !m_pend || pps_tick !== m_evt) begin
        n_fail++;
        $display("FAIL R1-model cycle compare: act t=%h c=%h a=%b r=%b p=%b exp t=%h c=%h a=%b r=%b p=%b",
                 time_now, time_at_pps, pps_armed, cmd_ready, pps_tick,
                 m_cnt, m_last, m_armed, !m_pend, m_evt);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at current falling edge, return at the next falling edge
  task automatic issue(input logic [1:0] op, input logic [63:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd3;
  endtask

  task automatic wait_tick();
    while (!pps_tick) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] t0, tp;
    int gap, ticks;
    repeat (4) @(negedge clk);
    chk("R8 reset count", time_now, 64'd0);
    chk("R8 reset armed", {63'd0, pps_armed}, 64'd0);
    chk("R8 reset ready", {63'd0, cmd_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk); t0 = time_now;
    @(negedge clk); chk("R8 free run", time_now, t0 + 64'd1);

    issue(2'd0, 64'd1000);
    chk("R1 set-now", time_now, 64'd1000);
    @(negedge clk); chk("R1 count resumes", time_now, 64'd1001);

    t0 = time_now;
    issue(2'd2, 64'd50);
    chk("R8 stall during adjust", {63'd0, cmd_ready}, 64'd0);
    @(negedge clk); chk("R3 adjust +50", time_now, t0 + 64'd52);
    chk("R8 ready after adjust", {63'd0, cmd_ready}, 64'd1);

    t0 = time_now;
    issue(2'd2, -64'sd100);
    @(negedge clk); chk("R3 adjust -100", time_now, t0 + 64'd2 - 64'd100);

    issue(2'd0, 64'hFFFF_FFFF_FFFF_FFFD);
    t0 = time_now;
    issue(2'd2, 64'd5);
    @(negedge clk); chk("R3 wrap", time_now, 64'd4);

    t0 = time_now;
    issue(2'd3, 64'd999);
    chk("R9 nop count", time_now, t0 + 64'd1);
    chk("R9 nop armed", {63'd0, pps_armed}, 64'd0);

    // external source
    issue(2'd1, 64'd5000);
    chk("R2 armed", {63'd0, pps_armed}, 64'd1);
    chk("R2 not loaded yet", {63'd0, time_now == 64'd5000}, 64'd0);
    pps_ext = 1'b1;
    @(negedge clk); chk("R6 no early tick", {63'd0, pps_tick}, 64'd0);
    @(negedge clk); chk("R6 tick after two edges", {63'd0, pps_tick}, 64'd1);
    tp = time_now;
    @(negedge clk);
    chk("R2 staged load", time_now, 64'd5000);
    chk("R2 disarm", {63'd0, pps_armed}, 64'd0);
    chk("R4 capture", time_at_pps, tp);
    ticks = 0;
    for (int i = 0; i < 10; i++) begin
      if (pps_tick) ticks++;
      @(negedge clk);
    end
    chk("R6 long pulse single event", 64'(ticks), 64'd0);
    pps_ext = 1'b0;
    repeat (3) @(negedge clk);
    pps_ext = 1'b1;
    repeat (2) @(negedge clk);
    tp = time_now;
    @(negedge clk);
    chk("R4 second capture", time_at_pps, tp);
    chk("R2 unarmed keeps counting", time_now, tp + 64'd1);
    pps_ext = 1'b0;

    // internal source
    pps_period = 32'd7; pps_int_sel = 1'b1;
    @(negedge clk); wait_tick();
    @(negedge clk); gap = 1;
    while (!pps_tick) begin @(negedge clk); gap++; end
    chk("R5 period", 64'(gap), 64'd7);

    // arm at the tick cycle itself, adjust collides with next load
    issue(2'd1, 64'd20000);
    chk("R2 event at accept not used", {63'd0, pps_armed}, 64'd1);
    repeat (5) @(negedge clk);
    issue(2'd2, 64'd10);
    chk("R7 tick with pending adjust", {63'd0, pps_tick}, 64'd1);
    @(negedge clk); chk("R7 load wins", time_now, 64'd20000);
    @(negedge clk); chk("R7 adjust after load", time_now, 64'd20011);

    issue(2'd1, 64'd30000);
    wait_tick();
    issue(2'd0, 64'd777);
    chk("R7 load beats set-now", time_now, 64'd30000);
    chk("R7 set-now deferred stall", {63'd0, cmd_ready}, 64'd0);
    @(negedge clk); chk("R7 deferred set-now", time_now, 64'd777);

    pps_period = 32'd1;
    @(negedge clk); wait_tick();
    @(negedge clk); chk("R5 min period", {63'd0, pps_tick}, 64'd0);
    @(negedge clk); chk("R5 min period tick", {63'd0, pps_tick}, 64'd1);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule